// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Check

This block is the integer data path of a simple pipelined processor's execute stage. It takes two operands, an operation select, a request to update the flags, the current negative/zero/carry/overflow flags, a shifter carry and a 4-bit condition field. In the same cycle it returns the operation result, the flags to be written back, a result-write enable and a condition-passed indication. It is purely combinational: the flag register and the register file live outside it.

Twelve operations produce a result: add and subtract with and without carry-in, reverse subtract with and without carry-in, AND, OR, XOR, bit clear, move and move-inverted. Four compare/test operations compute the same values but only update the flags and never request a result write. A condition evaluator checks the incoming flags against the condition field. When the condition fails, the write enable is low and the flags pass through unchanged.

Top module: `alu_flagcond`

## Requirements
- R1: Operation select (4 bits) encodes 0 ADD (a+b), 1 ADC (a+b+C), 2 SUB (a-b), 3 SBC (a-b-NOT C), 4 RSB (b-a), 5 RSC (b-a-NOT C), 6 CMP (a-b), 7 CMN (a+b), 8 AND, 9 ORR, 10 EOR, 11 BIC (a AND NOT b), 12 MOV (b), 13 MVN (NOT b), 14 TST (AND), 15 TEQ (XOR). The result is the value modulo 2^W.
- R2: When flags are updated, N equals the result's most significant bit and Z is 1 exactly when the result is zero. Flags are packed N,Z,C,V in bits 3,2,1,0.
- R3: For the arithmetic operations, C is the carry out of an addition and, for a subtraction, 1 when no borrow occurs (minuend >= subtrahend plus the borrow-in, unsigned). V is 1 when the signed result overflows. -1+1 gives 0 with NZCV=0110; (2^31-1)+1 gives 0x80000000 with NZCV=1001.
- R4: For the logical operations (8 to 15 minus none, i.e. codes 8-15), C takes the shifter carry input and V keeps its incoming value.
- R5: CMP, CMN, TST and TEQ update the flags whether or not the update request is set, and never assert the write enable.
- R6: For an operation that is not a compare form, with the update request low, the outgoing flags equal the incoming flags; the write enable follows the condition result.
- R7: Condition codes: 0 EQ Z=1, 1 NE Z=0, 2 CS C=1, 3 CC C=0, 4 MI N=1, 5 PL N=0, 6 VS V=1, 7 VC V=0, 8 HI C=1 and Z=0, 9 LS C=0 or Z=1, 10 GE N=V, 11 LT N!=V, 12 GT Z=0 and N=V, 13 LE Z=1 or N!=V, 14 always, 15 never.
- R8: When the condition fails, the write enable is low and the outgoing flags equal the incoming flags, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand (already shifted) |
| opsel_i | input | 4 | Operation select |
| setfl_i | input | 1 | Request to update flags |
| flags_i | input | 4 | Current N,Z,C,V |
| cond_i | input | 4 | Condition field |
| shcarry_i | input | 1 | Carry out of the operand shifter |
| res_o | output | W | Operation result |
| flags_o | output | 4 | Flags to write back |
| wren_o | output | 1 | Result write enable |
| pass_o | output | 1 | Condition passed |

## Verification
A 4-bit instance is swept over every operation, every operand pair and both carry-in values, with the update request, the incoming N/Z/V and the shifter carry varied as functions of the operands, so the sweep separates carry from borrow, signed overflow from unsigned carry, and compare forms from ordinary ones. All 16 flag values are crossed with all 16 condition codes to tell each condition apart and to show that a failed condition blocks both the write and the flag update. A 32-bit instance is tried with the sign-boundary additions, equal and unequal subtraction, and a held-flags case.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_RSC = 4'd5,
        OP_CMP = 4'd6,
        OP_CMN = 4'd7,
        OP_AND = 4'd8,
        OP_ORR = 4'd9,
        OP_EOR = 4'd10,
        OP_BIC = 4'd11,
        OP_MOV = 4'd12,
        OP_MVN = 4'd13,
        OP_TST = 4'd14,
        OP_TEQ = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_CS = 4'd2,
        CC_CC = 4'd3,
        CC_MI = 4'd4,
        CC_PL = 4'd5,
        CC_VS = 4'd6,
        CC_VC = 4'd7,
        CC_HI = 4'd8,
        CC_LS = 4'd9,
        CC_GE = 4'd10,
        CC_LT = 4'd11,
        CC_GT = 4'd12,
        CC_LE = 4'd13,
        CC_AL = 4'd14,
        CC_NV = 4'd15
    } cond_e;

    // Logical class occupies the upper half of the select space
    function automatic logic is_logical(opcode_e op);
        return op[3];
    endfunction

    function automatic logic is_compare(opcode_e op);
        return (op == OP_CMP) || (op == OP_CMN) ||
               (op == OP_TST) || (op == OP_TEQ);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        // Signed overflow: equal input signs, differing result sign
        ovf_o  = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  opcode_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] x, y;
    logic         cin;

    // All arithmetic forms map onto one adder by swapping and inverting
    always_comb begin
        x   = a_i;
        y   = b_i;
        cin = 1'b0;
        unique case (op_i)
            OP_ADD, OP_CMN: begin
                cin = 1'b0;
            end
            OP_ADC: begin
                cin = carry_i;
            end
            OP_SUB, OP_CMP: begin
                y   = ~b_i;
                cin = 1'b1;
            end
            OP_SBC: begin
                y   = ~b_i;
                cin = carry_i;
            end
            OP_RSB: begin
                x   = b_i;
                y   = ~a_i;
                cin = 1'b1;
            end
            OP_RSC: begin
                x   = b_i;
                y   = ~a_i;
                cin = carry_i;
            end
            default: begin
                x   = a_i;
                y   = b_i;
                cin = 1'b0;
            end
        endcase
    end

    alu_adder #(.W(W)) u_adder (
        .x_i   (x),
        .y_i   (y),
        .cin_i (cin),
        .sum_o (sum_o),
        .cout_o(cout_o),
        .ovf_o (ovf_o)
    );
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  opcode_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MOV:         res_o = b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_pkg::*;
(
    input  flags_t f_i,
    input  cond_e  cc_i,
    output logic   pass_o
);
    always_comb begin
        unique case (cc_i)
            CC_EQ: pass_o = f_i.z;
            CC_NE: pass_o = !f_i.z;
            CC_CS: pass_o = f_i.c;
            CC_CC: pass_o = !f_i.c;
            CC_MI: pass_o = f_i.n;
            CC_PL: pass_o = !f_i.n;
            CC_VS: pass_o = f_i.v;
            CC_VC: pass_o = !f_i.v;
            CC_HI: pass_o = f_i.c && !f_i.z;
            CC_LS: pass_o = !f_i.c || f_i.z;
            CC_GE: pass_o = (f_i.n == f_i.v);
            CC_LT: pass_o = (f_i.n != f_i.v);
            CC_GT: pass_o = !f_i.z && (f_i.n == f_i.v);
            CC_LE: pass_o = f_i.z || (f_i.n != f_i.v);
            CC_AL: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

    always_comb begin
        if (cc_i == CC_AL)
            p_always_r7: assert (pass_o) else $error("always condition did not pass");
        if (cc_i == CC_NV)
            p_never_r7: assert (!pass_o) else $error("never condition passed");
    end
endmodule

// File: rtl/alu_flagcond.sv
module alu_flagcond
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [3:0]   opsel_i,
    input  logic         setfl_i,
    input  logic [3:0]   flags_i,
    input  logic [3:0]   cond_i,
    input  logic         shcarry_i,
    output logic [W-1:0] res_o,
    output logic [3:0]   flags_o,
    output logic         wren_o,
    output logic         pass_o
);
    localparam int MSB = W - 1;

    opcode_e      op;
    flags_t       fin;
    flags_t       fnew;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic         arith_c;
    logic         arith_v;
    logic         lg;
    logic         cmp;
    logic         upd;

    assign op  = opcode_e'(opsel_i);
    assign fin = flags_t'(flags_i);
    assign lg  = is_logical(op);
    assign cmp = is_compare(op);

    alu_arith #(.W(W)) u_arith (
        .op_i   (op),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .carry_i(fin.c),
        .sum_o  (arith_res),
        .cout_o (arith_c),
        .ovf_o  (arith_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op_i (op),
        .a_i  (opa_i),
        .b_i  (opb_i),
        .res_o(logic_res)
    );

    alu_cond u_cond (
        .f_i   (fin),
        .cc_i  (cond_e'(cond_i)),
        .pass_o(pass_o)
    );

    always_comb begin
        res_o  = lg ? logic_res : arith_res;
        fnew.n = res_o[MSB];
        fnew.z = (res_o == '0);
        fnew.c = lg ? shcarry_i : arith_c;
        fnew.v = lg ? fin.v     : arith_v;
        upd     = pass_o && (setfl_i || cmp);
        flags_o = upd ? fnew : fin;
        wren_o  = pass_o && !cmp;
    end

    always_comb begin
        if (!pass_o)
            p_fail_hold_r8: assert (!wren_o && flags_o == flags_i)
                else $error("failed condition changed state");
        if (cmp)
            p_cmp_nowrite_r5: assert (!wren_o)
                else $error("compare form requested a write");
        if (pass_o && !setfl_i && !cmp)
            p_hold_flags_r6: assert (flags_o == flags_i && wren_o)
                else $error("flags changed without update request");
        if (lg)
            p_logic_v_r4: assert (flags_o[0] == flags_i[0])
                else $error("logical operation altered V");
        if (upd)
            p_zero_flag_r2: assert (flags_o[2] == (res_o == '0))
                else $error("Z does not match result");
    end
endmodule

// File: tb/test_alu_flagcond.sv
module test_alu_flagcond;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // 32-bit instance
    logic [31:0] s_a, s_b, s_res;
    logic [3:0]  s_op, s_fin, s_cc, s_fout;
    logic        s_set, s_shc, s_wr, s_pass;

    alu_flagcond #(.W(32)) i_alu_flagcond (
        .opa_i(s_a), .opb_i(s_b), .opsel_i(s_op), .setfl_i(s_set),
        .flags_i(s_fin), .cond_i(s_cc), .shcarry_i(s_shc),
        .res_o(s_res), .flags_o(s_fout), .wren_o(s_wr), .pass_o(s_pass)
    );

    // 4-bit instance for exhaustive sweeps
    logic [3:0] t_a, t_b, t_res, t_op, t_fin, t_cc, t_fout;
    logic       t_set, t_shc, t_wr, t_pass;

    alu_flagcond #(.W(4)) i_alu_flagcond_w4 (
        .opa_i(t_a), .opb_i(t_b), .opsel_i(t_op), .setfl_i(t_set),
        .flags_i(t_fin), .cond_i(t_cc), .shcarry_i(t_shc),
        .res_o(t_res), .flags_o(t_fout), .wren_o(t_wr), .pass_o(t_pass)
    );

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference model of a W=4 operation, from the requirement text
    function automatic void model4(input int op, input int a, input int b,
                                   input int fin, input int shc, input int setf,
                                   output int res, output int fout, output int wr);
        int cin, vin, sa, sb, r, s, c, v, n, z;
        bit lg, cmp;
        cin = (fin >> 1) & 1;
        vin = fin & 1;
        sa  = (a >= 8) ? a - 16 : a;
        sb  = (b >= 8) ? b - 16 : b;
        r = 0; s = 0; c = 0;
        case (op)
            0, 7: begin r = a + b;       s = sa + sb;       c = (r > 15); end
            1:    begin r = a + b + cin; s = sa + sb + cin; c = (r > 15); end
            2, 6: begin r = a - b;       s = sa - sb;       c = (a >= b); end
            3:    begin r = a - b - (1 - cin); s = sa - sb - (1 - cin); c = (a >= b + 1 - cin); end
            4:    begin r = b - a;       s = sb - sa;       c = (b >= a); end
            5:    begin r = b - a - (1 - cin); s = sb - sa - (1 - cin); c = (b >= a + 1 - cin); end
            8, 14: r = a & b;
            9:     r = a | b;
            10, 15: r = a ^ b;
            11:    r = a & ~b;
            12:    r = b;
            default: r = ~b;
        endcase
        res = r & 15;
        lg  = (op >= 8);
        cmp = (op == 6) || (op == 7) || (op == 14) || (op == 15);
        if (lg) begin
            c = shc;
            v = vin;
        end else begin
            v = (s > 7 || s < -8) ? 1 : 0;
        end
        n = (res >> 3) & 1;
        z = (res == 0) ? 1 : 0;
        fout = (setf != 0 || cmp) ? ((n << 3) | (z << 2) | (c << 1) | v) : fin;
        wr   = cmp ? 0 : 1;
    endfunction

    function automatic int cond_model(input int f, input int cc);
        int n, z, c, v;
        n = (f >> 3) & 1; z = (f >> 2) & 1; c = (f >> 1) & 1; v = f & 1;
        case (cc)
            0:  return z;
            1:  return 1 - z;
            2:  return c;
            3:  return 1 - c;
            4:  return n;
            5:  return 1 - n;
            6:  return v;
            7:  return 1 - v;
            8:  return (c == 1 && z == 0) ? 1 : 0;
            9:  return (c == 0 || z == 1) ? 1 : 0;
            10: return (n == v) ? 1 : 0;
            11: return (n != v) ? 1 : 0;
            12: return (z == 0 && n == v) ? 1 : 0;
            13: return (z == 1 || n != v) ? 1 : 0;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk32(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] op, input logic setf, input logic [3:0] fin,
                         input logic [3:0] cc, input logic [31:0] e_res,
                         input logic [3:0] e_f, input logic e_wr, input logic e_pass);
        @(negedge clk);
        s_a = a; s_b = b; s_op = op; s_set = setf; s_fin = fin; s_cc = cc; s_shc = 1'b0;
        #5;
        total++;
        if (s_res !== e_res || s_fout !== e_f || s_wr !== e_wr || s_pass !== e_pass) begin
            bad++;
            $display("FAIL %s: res/flags/wr/pass actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                     req, s_res, s_fout, s_wr, s_pass, e_res, e_f, e_wr, e_pass);
        end
    endtask

    initial begin
        int e_res, e_f, e_wr, e_p;
        string req;
        s_a = '0; s_b = '0; s_op = '0; s_set = 1'b0; s_fin = '0; s_cc = 4'd14; s_shc = 1'b0;
        t_a = '0; t_b = '0; t_op = '0; t_set = 1'b0; t_fin = '0; t_cc = 4'd14; t_shc = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: zero inputs, ADD, always, update requested
        chk32("R2 reset", 32'h0, 32'h0, 4'd0, 1'b1, 4'b0000, 4'd14, 32'h0, 4'b0100, 1'b1, 1'b1);

        // 32-bit boundary cases
        chk32("R3 -1+1", 32'hFFFF_FFFF, 32'h1, 4'd0, 1'b1, 4'b0000, 4'd14,
              32'h0, 4'b0110, 1'b1, 1'b1);
        chk32("R3 max+1", 32'h7FFF_FFFF, 32'h1, 4'd0, 1'b1, 4'b0000, 4'd14,
              32'h8000_0000, 4'b1001, 1'b1, 1'b1);
        chk32("R3 sub equal", 32'd5, 32'd5, 4'd2, 1'b1, 4'b0000, 4'd14,
              32'h0, 4'b0110, 1'b1, 1'b1);
        chk32("R3 sub borrow", 32'd3, 32'd5, 4'd2, 1'b1, 4'b0010, 4'd14,
              32'hFFFF_FFFE, 4'b1000, 1'b1, 1'b1);
        chk32("R1 RSB", 32'd3, 32'd10, 4'd4, 1'b1, 4'b0000, 4'd14,
              32'd7, 4'b0010, 1'b1, 1'b1);
        chk32("R6 hold", 32'hFFFF_FFFF, 32'h1, 4'd0, 1'b0, 4'b1011, 4'd14,
              32'h0, 4'b1011, 1'b1, 1'b1);
        chk32("R5 CMP", 32'd9, 32'd9, 4'd6, 1'b0, 4'b0000, 4'd14,
              32'h0, 4'b0110, 1'b0, 1'b1);
        chk32("R8 fail", 32'd1, 32'd2, 4'd0, 1'b1, 4'b0000, 4'd0,
              32'd3, 4'b0000, 1'b0, 1'b0);
        chk32("R7 never", 32'd1, 32'd2, 4'd0, 1'b1, 4'b1111, 4'd15,
              32'd3, 4'b1111, 1'b0, 1'b0);

        // Exhaustive 4-bit operation sweep
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        int fin, shc, setf;
                        fin  = (((b >> 1) & 1) << 3) | (((a >> 1) & 1) << 2) | (ci << 1) | ((a ^ b) & 1);
                        shc  = ((a >> 2) ^ (b >> 3)) & 1;
                        setf = (a ^ b ^ op ^ (a >> 3)) & 1;
                        model4(op, a, b, fin, shc, setf, e_res, e_f, e_wr);
                        if (op == 6 || op == 7 || op == 14 || op == 15) req = "R5";
                        else if (setf == 0) req = "R6";
                        else if (op >= 8) req = "R4 R2";
                        else req = "R1 R2 R3";
                        @(negedge clk);
                        t_op = 4'(op); t_a = 4'(a); t_b = 4'(b); t_fin = 4'(fin);
                        t_shc = shc[0]; t_set = setf[0]; t_cc = 4'd14;
                        #5;
                        total++;
                        if (t_res !== 4'(e_res) || t_fout !== 4'(e_f) ||
                            t_wr !== e_wr[0] || t_pass !== 1'b1) begin
                            bad++;
                            $display("FAIL %s op=%0d a=%0d b=%0d c=%0d: res/flags/wr/pass actual=%h/%b/%b/%b expected=%h/%b/%b/1",
                                     req, op, a, b, ci, t_res, t_fout, t_wr, t_pass,
                                     4'(e_res), 4'(e_f), e_wr[0]);
                        end
                    end
                end
            end
        end

        // Condition sweep: every flag value against every condition code (R7, R8)
        for (int f = 0; f < 16; f++) begin
            for (int cc = 0; cc < 16; cc++) begin
                e_p = cond_model(f, cc);
                @(negedge clk);
                t_op = 4'd12; t_a = 4'd0; t_b = 4'd0; t_set = 1'b1; t_shc = 1'b1;
                t_fin = 4'(f); t_cc = 4'(cc);
                #5;
                // MOV of zero with carry-in 1 from shifter: new flags 0110 plus held V
                e_f  = (e_p != 0) ? (4'b0110 | (f & 1)) : f;
                e_wr = e_p;
                total++;
                if (t_pass !== e_p[0] || t_wr !== e_wr[0] || t_fout !== 4'(e_f)) begin
                    bad++;
                    $display("FAIL R7/R8 flags=%b cc=%0d: pass/wr/flags actual=%b/%b/%b expected=%b/%b/%b",
                             4'(f), cc, t_pass, t_wr, t_fout, e_p[0], e_wr[0], 4'(e_f));
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule